// File: doc/BRIEF.md
# Hart Local Interrupt Selector

This block decides, once per clock, whether a processor core should take one of its local interrupts and which one. It takes a pending vector, an enable vector and a delegation mask of equal width, along with the current privilege level and the global machine and supervisor interrupt-enable status bits. It returns a take-interrupt flag and the cause number of the chosen interrupt.

A line that is both pending and enabled is a candidate. Each candidate is then gated at one of two levels. If its delegation bit is clear, it is gated at machine level. If its delegation bit is set, it is gated at supervisor level. Among the candidates that survive, the lowest-numbered one wins.

The result is registered through a two-state output machine. The states are `ST_QUIET` (no interrupt signalled) and `ST_SIGNAL` (interrupt signalled with a cause). The transition `QUIET->SIGNAL` fires when the gated set is nonzero. The transition `SIGNAL->QUIET` fires when the gated set is zero. The self-loops hold the state, and in `ST_SIGNAL` the cause is reloaded on every edge. Reset forces `ST_QUIET`. The vector width is a parameter, normally 32 or 64.

Top module: `irq_local_select`

## Requirements
- R1: A line is a candidate only if its pending bit and its enable bit are both 1. A pending line whose enable bit is 0 is never selected.
- R2: A candidate whose delegation bit is 0 is allowed when the privilege is not M (code 3). It is also allowed at M when the machine interrupt-enable input is 1.
- R3: A candidate whose delegation bit is 1 is allowed when the privilege is U (code 0). It is also allowed at S (code 1) when the supervisor interrupt-enable input is 1. It is blocked at code 2 and at M, whatever the enable inputs are.
- R4: When several candidates are allowed, the cause is the index of the lowest-numbered one.
- R5: `take_o` is 1 exactly when at least one candidate is allowed. `cause_o` is then the index of the selected line.
- R6: When no candidate is allowed, `take_o` is 0 and `cause_o` is 0.
- R7: The outputs reflect the inputs sampled at the previous rising clock edge: a latency of one cycle. Between edges the outputs do not change.
- R8: While `rst_n` is low, and after reset until the first active edge, `take_o` is 0 and `cause_o` is 0.
- R9: Privilege code 2 counts as below M and above S. At code 2, non-delegated candidates are allowed whatever the machine enable is, and delegated candidates are blocked.
- R10: The topmost line, index W-1, can be selected. It then reports cause W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pend_i | input | W | Pending interrupt lines |
| enab_i | input | W | Per-line enables |
| deleg_i | input | W | Delegation mask: 1 gates the line at supervisor level |
| priv_i | input | 2 | Current privilege: 0=U, 1=S, 2=reserved, 3=M |
| mie_i | input | 1 | Global machine interrupt enable |
| sie_i | input | 1 | Global supervisor interrupt enable |
| take_o | output | 1 | Interrupt to be taken (registered) |
| cause_o | output | $clog2(W) | Index of the selected line (registered) |

## Verification
Every result is due exactly one rising edge after the inputs that produce it are applied. The gating and lowest-index pick are combinational, and the only register on the path is the output machine. The bench drives each input pattern on a falling edge and lets one rising edge pass. It then compares `take_o` and `cause_o` on the following falling edge. For the latency case, the bench also samples just after a new pattern is driven but before the next rising edge, to confirm that the earlier result is still held.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    typedef enum logic [1:0] {
        PRIV_U   = 2'd0,
        PRIV_S   = 2'd1,
        PRIV_RSV = 2'd2,
        PRIV_M   = 2'd3
    } priv_e;

    typedef enum logic {
        ST_QUIET  = 1'b0,
        ST_SIGNAL = 1'b1
    } out_state_e;

endpackage

// File: rtl/irq_level_gate.sv
module irq_level_gate
    import irq_sel_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [W-1:0] pend_i,
    input  logic [W-1:0] enab_i,
    input  logic [W-1:0] deleg_i,
    input  logic [1:0]   priv_i,
    input  logic         mie_i,
    input  logic         sie_i,
    output logic [W-1:0] allowed_o
);
    priv_e       priv;
    logic        m_level_on;
    logic        s_level_on;
    logic [W-1:0] cand;

    always_comb begin
        priv       = priv_e'(priv_i);
        cand       = pend_i & enab_i;
        // machine level: anything below M, or M with its enable set
        m_level_on = (priv != PRIV_M) || mie_i;
        // supervisor level: only U, or S with its enable set
        s_level_on = (priv == PRIV_U) || ((priv == PRIV_S) && sie_i);
        allowed_o  = (cand & ~deleg_i & {W{m_level_on}})
                   | (cand &  deleg_i & {W{s_level_on}});
    end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int W  = 64,
    localparam int CW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic          any_o,
    output logic [CW-1:0] idx_o
);
    always_comb begin
        any_o = |vec_i;
        idx_o = '0;
        // scan downward so the lowest set bit is written last
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = CW'(i);
        end
    end
endmodule

// File: rtl/irq_local_select.sv
module irq_local_select
    import irq_sel_pkg::*;
#(
    parameter int W  = 64,
    localparam int CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  pend_i,
    input  logic [W-1:0]  enab_i,
    input  logic [W-1:0]  deleg_i,
    input  logic [1:0]    priv_i,
    input  logic          mie_i,
    input  logic          sie_i,
    output logic          take_o,
    output logic [CW-1:0] cause_o
);
    logic [W-1:0]  allowed;
    logic          any_hit;
    logic [CW-1:0] hit_idx;

    out_state_e    state_q, state_d;
    logic [CW-1:0] cause_q, cause_d;

    irq_level_gate #(.W(W)) u_gate (
        .pend_i   (pend_i),
        .enab_i   (enab_i),
        .deleg_i  (deleg_i),
        .priv_i   (priv_i),
        .mie_i    (mie_i),
        .sie_i    (sie_i),
        .allowed_o(allowed)
    );

    irq_lsb_pick #(.W(W)) u_pick (
        .vec_i(allowed),
        .any_o(any_hit),
        .idx_o(hit_idx)
    );

    always_comb begin
        state_d = state_q;
        cause_d = '0;
        unique case (state_q)
            ST_QUIET: begin
                if (any_hit) begin
                    state_d = ST_SIGNAL;
                    cause_d = hit_idx;
                end
            end
            ST_SIGNAL: begin
                if (any_hit) begin
                    cause_d = hit_idx;
                end else begin
                    state_d = ST_QUIET;
                end
            end
            default: state_d = ST_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_QUIET;
            cause_q <= '0;
        end else begin
            state_q <= state_d;
            cause_q <= cause_d;
        end
    end

    always_comb begin
        take_o  = (state_q == ST_SIGNAL);
        cause_o = cause_q;
    end
endmodule

// File: rtl/irq_local_select_chk.sv
module irq_local_select_chk #(
    parameter int W  = 64,
    localparam int CW = $clog2(W)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [W-1:0]  pend_i,
    input logic [W-1:0]  enab_i,
    input logic [W-1:0]  deleg_i,
    input logic [1:0]    priv_i,
    input logic          mie_i,
    input logic          sie_i,
    input logic          take_o,
    input logic [CW-1:0] cause_o
);
    // R6: quiet output always reports cause 0
    a_r6_quiet_cause_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> cause_o == '0);

    // R1: with no pending-and-enabled line last edge, nothing is taken
    a_r1_no_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past((pend_i & enab_i) == '0)) |-> !take_o);

    // R5: the reported cause was a candidate at the previous edge
    a_r5_cause_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && take_o) |->
            |($past(pend_i & enab_i) & (W'(1) << cause_o)));

    // R2 and R3: at M with both enables off, every level is blocked
    a_r2_m_all_off: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv_i == 2'd3 && !mie_i && !sie_i)) |-> !take_o);

    // R3: at U both levels are open, so any candidate is taken
    a_r3_user_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv_i == 2'd0 && (pend_i & enab_i) != '0)) |-> take_o);

    // R9: at code 2 delegated lines alone never produce a take
    a_r9_rsv_blocks_deleg: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(priv_i == 2'd2 && (pend_i & enab_i & ~deleg_i) == '0))
            |-> !take_o);
endmodule

bind irq_local_select irq_local_select_chk #(.W(W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend_i),
    .enab_i (enab_i),
    .deleg_i(deleg_i),
    .priv_i (priv_i),
    .mie_i  (mie_i),
    .sie_i  (sie_i),
    .take_o (take_o),
    .cause_o(cause_o)
);

// File: tb/irq_local_select_bench.sv
`timescale 1ns/1ps
module irq_local_select_bench;
    localparam int W  = 64;
    localparam int CW = $clog2(W);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [W-1:0]  pend = '0, enab = '0, deleg = '0;
    logic [1:0]    priv = 2'd0;
    logic          mie = 1'b0, sie = 1'b0;
    logic          take;
    logic [CW-1:0] cause;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    irq_local_select #(.W(W)) u_irq_local_select (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .enab_i(enab), .deleg_i(deleg),
        .priv_i(priv), .mie_i(mie), .sie_i(sie), .take_o(take), .cause_o(cause)
    );

    function automatic logic [W-1:0] bit_at(int i);
        return W'(1) << i;
    endfunction

    task automatic check(input logic exp_take, input int exp_cause, input string req);
        n_cmp++;
        if (take !== exp_take || cause !== CW'(exp_cause)) begin
            n_bad++;
            $display("FAIL %s: take=%0b cause=%0d expected take=%0b cause=%0d",
                     req, take, cause, exp_take, exp_cause);
        end
    endtask

    task automatic apply(input logic [W-1:0] p, input logic [W-1:0] e, input logic [W-1:0] d,
                         input logic [1:0] pv, input logic m, input logic s);
        @(negedge clk);
        pend = p; enab = e; deleg = d; priv = pv; mie = m; sie = s;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        check(1'b0, 0, "R8 in reset");
        @(negedge clk); rst_n = 1'b1;
        #1 check(1'b0, 0, "R8 after release");
    endtask

    task automatic t_enable_gate;
        apply(bit_at(5) | bit_at(9), bit_at(9), '0, 2'd0, 1'b0, 1'b0);
        check(1'b1, 9, "R1 disabled line 5 skipped");
        apply(bit_at(3), '0, '0, 2'd0, 1'b1, 1'b1);
        check(1'b0, 0, "R1/R6 pending but disabled");
    endtask

    task automatic t_lowest;
        apply(64'hF0 | bit_at(40), '1, '0, 2'd0, 1'b0, 1'b0);
        check(1'b1, 4, "R4 lowest of several");
        apply(bit_at(W - 1), '1, '0, 2'd0, 1'b0, 1'b0);
        check(1'b1, W - 1, "R10 top line");
        apply(bit_at(0) | bit_at(W - 1), '1, '0, 2'd0, 1'b0, 1'b0);
        check(1'b1, 0, "R5 line 0 taken");
    endtask

    task automatic t_mlevel;
        apply(bit_at(7), '1, '0, 2'd3, 1'b0, 1'b1);
        check(1'b0, 0, "R2 M with machine enable off");
        apply(bit_at(7), '1, '0, 2'd3, 1'b1, 1'b0);
        check(1'b1, 7, "R2 M with machine enable on");
        apply(bit_at(7), '1, '0, 2'd1, 1'b0, 1'b0);
        check(1'b1, 7, "R2 below M");
    endtask

    task automatic t_slevel;
        apply(bit_at(7), '1, bit_at(7), 2'd1, 1'b1, 1'b0);
        check(1'b0, 0, "R3 S with supervisor enable off");
        apply(bit_at(7), '1, bit_at(7), 2'd1, 1'b0, 1'b1);
        check(1'b1, 7, "R3 S with supervisor enable on");
        apply(bit_at(7), '1, bit_at(7), 2'd3, 1'b1, 1'b1);
        check(1'b0, 0, "R3 delegated blocked at M");
        apply(bit_at(7), '1, bit_at(7), 2'd0, 1'b0, 1'b0);
        check(1'b1, 7, "R3 delegated at U");
    endtask

    task automatic t_priv2;
        apply(bit_at(11), '1, '0, 2'd2, 1'b0, 1'b0);
        check(1'b1, 11, "R9 code 2 machine level open");
        apply(bit_at(11), '1, bit_at(11), 2'd2, 1'b1, 1'b1);
        check(1'b0, 0, "R9 code 2 delegated blocked");
    endtask

    task automatic t_mixed;
        apply(bit_at(2) | bit_at(20), '1, bit_at(2), 2'd3, 1'b1, 1'b1);
        check(1'b1, 20, "R2/R3 delegated low line skipped at M");
        apply(bit_at(2) | bit_at(20), '1, bit_at(2), 2'd1, 1'b0, 1'b1);
        check(1'b1, 2, "R4 mixed levels at S");
    endtask

    task automatic t_latency;
        apply(bit_at(30), '1, '0, 2'd0, 1'b0, 1'b0);
        check(1'b1, 30, "R7 result after one edge");
        @(negedge clk);
        pend = '0;
        #1 check(1'b1, 30, "R7 held before edge");
        @(posedge clk);
        @(negedge clk);
        check(1'b0, 0, "R7/R6 cleared after edge");
    endtask

    initial begin
        #100000;
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: run did not complete (actual hung, expected done)");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        t_reset();
        t_enable_gate();
        t_lowest();
        t_mlevel();
        t_slevel();
        t_priv2();
        t_mixed();
        t_latency();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule